// File: doc/BRIEF.md
# Midrange Window Chip Select with Shared Refresh Strobe

This block turns bus addresses into four active-low chip selects for one programmable memory window. Software-visible configuration supplies the window base and a size code. The window is always a power of two between 8 KB and 512 KB and is split into four equal quarters. Each quarter owns one select line. A select goes low one clock after a valid memory cycle whose address falls inside that quarter.

The fourth select line can be given over to pseudo-static RAM refresh. When the refresh mode bit is set, that line stops decoding the top quarter. Each refresh request tick from an external interval timer then produces an active-low strobe lasting one and a half clocks. The block uses both clock edges to shape the strobe. After each strobe the line stays high for a fixed recovery time. A tick that arrives while a strobe or its recovery is running is kept and served later. While the bus is held by another master, every select stays high and no new strobe starts.

Top module: `midrange_cs_top`

## Requirements
- R1: The window holds an address when every address bit at or above position 13+S matches the base, where S is the `win_size` code. Codes 0..6 give 8 KB..512 KB, and codes above 6 are treated as 6.
- R2: For a hit, the quarter index is address bits [12+S:11+S]. Index k drives `sel_n[k]` low and the other lines high, registered one clock after the inputs are sampled.
- R3: No select goes low unless `mem_valid` is 1 and `io_cycle` is 0. An I/O cycle or an idle bus leaves `sel_n` at 4'b1111.
- R4: While `bus_hold` is 1, all four lines are high. This takes effect one clock later for decoded selects and at once for the refresh strobe, and no strobe starts during hold.
- R5: After reset all selects are high and the refresh mode bit is clear, so the top quarter decodes onto `sel_n[3]`.
- R6: A clock with `mode_wr` at 1 loads `mode_din` into the refresh mode bit. While that bit is 1, a top-quarter access leaves `sel_n[3]` high.
- R7: With the mode bit set, no hold and no strobe or recovery running, a tick sampled on a rising edge drives `sel_n[3]` low from that edge until the falling edge of the following cycle, which is 1.5 clocks.
- R8: After a strobe ends, `sel_n[3]` stays high for at least RECOV_CYC full clocks before the next strobe begins.
- R9: A tick that arrives during a strobe, during recovery or during hold is kept pending. It starts a strobe on the first rising edge on which that is allowed, so with the default RECOV_CYC=6 a retriggered strobe falls 8 clocks after the first one.
- R10: With the mode bit clear, ticks have no effect on `sel_n[3]`.
- R11: Base bits below the window size are ignored, so a base that is not aligned acts as if its low bits were zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the strobe also uses its falling edge |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 20 | Bus address of the current cycle |
| mem_valid | input | 1 | A bus cycle is valid this clock |
| io_cycle | input | 1 | 1 for I/O space, 0 for memory space |
| bus_hold | input | 1 | Bus handed to another master |
| win_base | input | 20 | Window base address |
| win_size | input | 3 | Window size code, 8 KB shifted left by the code |
| mode_wr | input | 1 | Load strobe for the refresh mode bit |
| mode_din | input | 1 | New refresh mode bit value |
| refresh_tick | input | 1 | One-clock refresh request from the interval timer |
| sel_n | output | 4 | Active-low quarter selects; bit 3 is shared with the refresh strobe |

## Verification
The checker assumes that `refresh_tick` is a single-clock pulse. It also assumes that the address, base and size inputs stay steady across each sampling edge, and that RECOV_CYC is at least one. The stimulus changes every input only on falling edges. It raises the tick for one clock at a time, and it never leaves the tick high across the edge where a strobe would begin, except in the cases that deliberately test pending behaviour. The at-most-one-low check on the lower three lines relies on the decode producing a single quarter index, which holds for any size code.

// File: rtl/midrange_cs_pkg.sv
// Shared types and helpers for the midrange window chip select.
// Assumes the size code fits in three bits and that window sizes are powers of two.
package midrange_cs_pkg;

    typedef enum logic [1:0] {
        RF_IDLE  = 2'd0,
        RF_PULSE = 2'd1,
        RF_RECOV = 2'd2
    } rf_state_t;

    // Returns log2 of the window size in bytes, clamping codes past the largest size.
    function automatic int win_log2(input logic [2:0] code, input int min_log2, input int num_sizes);
        int c;
        c = int'(code);
        if (c > num_sizes - 1) c = num_sizes - 1;
        return min_log2 + c;
    endfunction

endpackage

// File: rtl/midrange_cs_decode.sv
// Window hit and quarter index decode. This logic is purely combinational.
// Assumes ADDR_W >= MIN_LOG2 + NUM_SIZES - 1, so that the largest window fits in the address.
module midrange_cs_decode
    import midrange_cs_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int MIN_LOG2  = 13,
    parameter int NUM_SIZES = 7,
    parameter int SIZE_W    = 3
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] win_base,
    input  logic [SIZE_W-1:0] win_size,
    output logic              hit,
    output logic [1:0]        region
);

    logic [ADDR_W-1:0] keep_mask;
    int                lg;

    // Compare the bits above the window size and pick the two bits just below that boundary.
    always_comb begin
        lg = win_log2(3'(win_size), MIN_LOG2, NUM_SIZES);
        for (int i = 0; i < ADDR_W; i++) begin
            keep_mask[i] = (i >= lg);
        end
        hit    = (((addr ^ win_base) & keep_mask) == '0);
        region = 2'(addr >> (lg - 2));
    end

endmodule

// File: rtl/midrange_cs_refresh.sv
// Refresh strobe generator. It makes a 1.5-clock active-low strobe, followed by a recovery gap.
// The rising edge starts the strobe and the falling edge of the second cycle ends it.
// Assumes RECOV_CYC >= 1 and that the tick is a one-clock pulse.
module midrange_cs_refresh
    import midrange_cs_pkg::*;
#(
    parameter int RECOV_CYC = 6,
    localparam int CNT_W    = $clog2(RECOV_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic hold,
    input  logic tick,
    output logic pulse_active,
    output logic strobe_n
);

    rf_state_t        state;
    logic             second_ph;
    logic [CNT_W-1:0] gap_cnt;
    logic             pending;
    logic             half_done;
    logic             start_ok;

    assign start_ok     = enable && !hold && (tick || pending);
    assign pulse_active = (state == RF_PULSE);

    // Sequence idle, strobe and recovery, and remember ticks that cannot be served yet.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= RF_IDLE;
            second_ph <= 1'b0;
            gap_cnt   <= '0;
            pending   <= 1'b0;
        end else begin
            pending <= enable && (pending || tick);
            case (state)
                RF_IDLE: begin
                    if (start_ok) begin
                        state     <= RF_PULSE;
                        second_ph <= 1'b0;
                        pending   <= 1'b0;
                    end
                end
                RF_PULSE: begin
                    if (!second_ph) begin
                        second_ph <= 1'b1;
                    end else begin
                        second_ph <= 1'b0;
                        state     <= RF_RECOV;
                        gap_cnt   <= CNT_W'(RECOV_CYC - 1);
                    end
                end
                RF_RECOV: begin
                    if (gap_cnt == '0) begin
                        if (start_ok) begin
                            state   <= RF_PULSE;
                            pending <= 1'b0;
                        end else begin
                            state <= RF_IDLE;
                        end
                    end else begin
                        gap_cnt <= gap_cnt - 1'b1;
                    end
                end
                default: state <= RF_IDLE;
            endcase
        end
    end

    // On the falling edge mark the midpoint of the second strobe cycle.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            half_done <= 1'b0;
        end else begin
            half_done <= pulse_active && second_ph;
        end
    end

    assign strobe_n = !(pulse_active && !half_done);

endmodule

// File: rtl/midrange_cs_top.sv
// Midrange window chip select top. It registers four quarter selects and can share
// the last line with the refresh strobe. Hold forces every line inactive.
// Assumes the inputs are synchronous to clk.
module midrange_cs_top
    import midrange_cs_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int MIN_LOG2  = 13,
    parameter int NUM_SIZES = 7,
    parameter int SIZE_W    = 3,
    parameter int RECOV_CYC = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              mem_valid,
    input  logic              io_cycle,
    input  logic              bus_hold,
    input  logic [ADDR_W-1:0] win_base,
    input  logic [SIZE_W-1:0] win_size,
    input  logic              mode_wr,
    input  logic              mode_din,
    input  logic              refresh_tick,
    output logic [3:0]        sel_n
);

    localparam int NUM_REG = 4;

    logic               hit;
    logic [1:0]         region;
    logic               mode_q;
    logic [NUM_REG-1:0] sel_q;
    logic [NUM_REG-1:0] sel_d;
    logic               pulse_active;
    logic               strobe_n;

    midrange_cs_decode #(
        .ADDR_W   (ADDR_W),
        .MIN_LOG2 (MIN_LOG2),
        .NUM_SIZES(NUM_SIZES),
        .SIZE_W   (SIZE_W)
    ) u_decode (
        .addr    (addr),
        .win_base(win_base),
        .win_size(win_size),
        .hit     (hit),
        .region  (region)
    );

    midrange_cs_refresh #(
        .RECOV_CYC(RECOV_CYC)
    ) u_refresh (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (mode_q),
        .hold        (bus_hold),
        .tick        (refresh_tick),
        .pulse_active(pulse_active),
        .strobe_n    (strobe_n)
    );

    // Hold the refresh mode bit and clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
        end else if (mode_wr) begin
            mode_q <= mode_din;
        end
    end

    // Work out the next select pattern from the cycle type, hold and decode.
    always_comb begin
        sel_d = '1;
        if (mem_valid && !io_cycle && !bus_hold && hit) begin
            sel_d[region] = 1'b0;
        end
        if (mode_q) begin
            sel_d[NUM_REG-1] = 1'b1;
        end
    end

    // Register the select pattern.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '1;
        end else begin
            sel_q <= sel_d;
        end
    end

    // Drive the lines. The last line carries the refresh strobe in refresh mode.
    for (genvar k = 0; k < NUM_REG; k++) begin : g_line
        if (k == NUM_REG - 1) begin : g_shared
            assign sel_n[k] = mode_q ? (strobe_n || bus_hold) : sel_q[k];
        end else begin : g_plain
            assign sel_n[k] = sel_q[k];
        end
    end

endmodule

// File: rtl/midrange_cs_chk.sv
// Property checker for midrange_cs_top, attached with bind.
// Assumes a one-clock refresh tick and RECOV_CYC >= 1.
module midrange_cs_chk #(
    parameter int RECOV_CYC = 6,
    localparam int GW       = $clog2(RECOV_CYC + 1)
) (
    input logic       clk,
    input logic       rst_n,
    input logic       mem_valid,
    input logic       io_cycle,
    input logic       bus_hold,
    input logic       mode_q,
    input logic       pulse_active,
    input logic [3:0] sel_n
);

    logic [GW-1:0] idle_run;

    // Count the clocks since the last strobe, stopping at the recovery length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_run <= GW'(RECOV_CYC);
        end else if (pulse_active) begin
            idle_run <= '0;
        end else if (idle_run != GW'(RECOV_CYC)) begin
            idle_run <= idle_run + 1'b1;
        end
    end

    // R4
    hold_forces_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_hold |=> (sel_n[2:0] == 3'b111));

    // R3
    idle_bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_valid || io_cycle) |=> (sel_n[2:0] == 3'b111));

    // R2
    one_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_q |-> $onehot0(~sel_n));

    // R7
    strobe_two_edges_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_active) |=> pulse_active);

    // R7
    strobe_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_active && $past(pulse_active)) |=> !pulse_active);

    // R8
    recovery_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_active) |-> (idle_run >= GW'(RECOV_CYC)));

    // R10
    no_strobe_off_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q && !$past(mode_q)) |-> !pulse_active);

endmodule

bind midrange_cs_top midrange_cs_chk #(
    .RECOV_CYC(RECOV_CYC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_valid   (mem_valid),
    .io_cycle    (io_cycle),
    .bus_hold    (bus_hold),
    .mode_q      (mode_q),
    .pulse_active(pulse_active),
    .sel_n       (sel_n)
);

// File: tb/midrange_cs_top_bench.sv
`timescale 1ns/100ps
module midrange_cs_top_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] addr = '0;
    logic        mem_valid = 1'b0;
    logic        io_cycle = 1'b0;
    logic        bus_hold = 1'b0;
    logic [19:0] win_base = '0;
    logic [2:0]  win_size = '0;
    logic        mode_wr = 1'b0;
    logic        mode_din = 1'b0;
    logic        refresh_tick = 1'b0;
    logic [3:0]  sel_n;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    midrange_cs_top u_midrange_cs_top (
        .clk(clk), .rst_n(rst_n), .addr(addr), .mem_valid(mem_valid),
        .io_cycle(io_cycle), .bus_hold(bus_hold), .win_base(win_base),
        .win_size(win_size), .mode_wr(mode_wr), .mode_din(mode_din),
        .refresh_tick(refresh_tick), .sel_n(sel_n)
    );

    // Vector fields: addr, base, size, valid, io, expected sel_n
    localparam int NV = 10;
    localparam logic [48:0] VEC [NV] = '{
        {20'h40000, 20'h40000, 3'd0, 1'b1, 1'b0, 4'b1110},  // R2 quarter 0
        {20'h41FFF, 20'h40000, 3'd0, 1'b1, 1'b0, 4'b0111},  // R2 quarter 3
        {20'h42000, 20'h40000, 3'd0, 1'b1, 1'b0, 4'b1111},  // R1 miss
        {20'h24000, 20'h20000, 3'd3, 1'b1, 1'b0, 4'b1101},  // R1 64 KB
        {20'hD0000, 20'h80000, 3'd6, 1'b1, 1'b0, 4'b1011},  // R1 512 KB
        {20'hD0000, 20'h80000, 3'd6, 1'b1, 1'b1, 4'b1111},  // R3 io
        {20'hD0000, 20'h80000, 3'd6, 1'b0, 1'b0, 4'b1111},  // R3 idle
        {20'h2A000, 20'h2ABCD, 3'd3, 1'b1, 1'b0, 4'b1011},  // R11 misaligned
        {20'h7FFFF, 20'h00000, 3'd7, 1'b1, 1'b0, 4'b0111},  // R1 clamp
        {20'h80000, 20'hC0000, 3'd5, 1'b1, 1'b0, 4'b1111}   // R1 256 KB miss
    };

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: sel_n=%b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic access(input logic [19:0] a, input logic [19:0] b, input logic [2:0] s,
                          input logic v, input logic io);
        @(negedge clk);
        addr = a; win_base = b; win_size = s; mem_valid = v; io_cycle = io;
        @(posedge clk);
        #1;
    endtask

    task automatic set_mode(input logic m);
        @(negedge clk);
        mode_wr = 1'b1; mode_din = m;
        @(negedge clk);
        mode_wr = 1'b0;
    endtask

    initial begin
        #200000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        // R5: reset holds lines high even with a hitting access
        addr = 20'h41FFF; win_base = 20'h40000; win_size = 3'd0; mem_valid = 1'b1;
        repeat (3) @(posedge clk);
        #1 check("R5 reset", sel_n, 4'b1111);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk);
        #1 check("R5 mode clear after reset", sel_n, 4'b0111);

        for (int i = 0; i < NV; i++) begin
            access(VEC[i][48:29], VEC[i][28:9], VEC[i][8:6], VEC[i][5], VEC[i][4]);
            check("R1/R2/R3/R11 vector", sel_n, VEC[i][3:0]);
        end

        // R4: hold forces all high
        @(negedge clk) bus_hold = 1'b1;
        access(20'h40000, 20'h40000, 3'd0, 1'b1, 1'b0);
        check("R4 hold", sel_n, 4'b1111);
        @(negedge clk) bus_hold = 1'b0;
        access(20'h40000, 20'h40000, 3'd0, 1'b1, 1'b0);
        check("R4 release", sel_n, 4'b1110);

        // R10: ticks ignored with mode clear
        access(20'h00000, 20'h40000, 3'd0, 1'b0, 1'b0);
        @(negedge clk) refresh_tick = 1'b1;
        @(posedge clk);
        #1 check("R10 no strobe", sel_n, 4'b1111);
        @(negedge clk) refresh_tick = 1'b0;
        #3.5 check("R10 no strobe later", sel_n, 4'b1111);

        // R6: mode set hides the top quarter
        set_mode(1'b1);
        access(20'h41FFF, 20'h40000, 3'd0, 1'b1, 1'b0);
        check("R6 top quarter suppressed", sel_n, 4'b1111);
        access(20'h00000, 20'h40000, 3'd0, 1'b0, 1'b0);

        // R7: strobe shape
        repeat (10) @(posedge clk);
        @(negedge clk) refresh_tick = 1'b1;
        @(posedge clk);
        #1 check("R7 strobe start", sel_n, 4'b0111);
        #1.5 refresh_tick = 1'b0;
        #1.5 check("R7 after first fall edge", sel_n, 4'b0111);
        #2 check("R7 second cycle first half", sel_n, 4'b0111);
        #2.5 check("R7 ends at 1.5 clocks", sel_n, 4'b1111);

        // R8/R9: retrigger during the strobe is served after recovery
        repeat (10) @(posedge clk);
        @(negedge clk) refresh_tick = 1'b1;     // sampled at P0
        @(negedge clk) refresh_tick = 1'b0;
        @(negedge clk) refresh_tick = 1'b1;     // sampled at P2
        @(negedge clk) refresh_tick = 1'b0;
        repeat (5) @(posedge clk);              // P3..P7
        #1 check("R8 recovery still high", sel_n, 4'b1111);
        @(posedge clk);                          // P8
        #1 check("R9 pending strobe", sel_n, 4'b0111);

        // R4/R9: tick during hold waits for release
        repeat (12) @(posedge clk);
        @(negedge clk) begin bus_hold = 1'b1; refresh_tick = 1'b1; end
        @(negedge clk) refresh_tick = 1'b0;
        @(posedge clk);
        #1 check("R4 no strobe in hold", sel_n, 4'b1111);
        @(negedge clk) bus_hold = 1'b0;
        @(posedge clk);
        #1 check("R9 strobe after hold", sel_n, 4'b0111);

        // R6: clear mode, top quarter decodes again
        repeat (10) @(posedge clk);
        set_mode(1'b0);
        access(20'h41FFF, 20'h40000, 3'd0, 1'b1, 1'b0);
        check("R6 mode cleared", sel_n, 4'b0111);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule